// File: doc/BRIEF.md
# Dual-Bank Aliased Address Map

This block turns a virtual word address into a physical byte address. It looks the address up in a per-page status table and then in one of two banks of map entries, a left bank and a right bank. The page index is split into an alias field (the top bits) and a bank index. Every page that shares a bank index competes for the same two slots, so two aliasing pages can be mapped at once, one in each bank. Each map entry carries an access bit, a write bit, a cache-inhibit bit and a physical page number. The block checks read and write permission against those bits and reports one of three outcomes: hit, miss or permission fault.

On a miss, the surrounding logic supplies a refill: the page number, a 32-bit map entry, and a flag that marks the page as pinned. A usage table has one entry for each pair of map pages, that is, for each bank index with its low bit dropped. That entry picks the bank and evicts that bank's current owner. The owner's status entries for both halves of its pair are cleared. The refill then writes the new map entry, records the new owner and updates the alternation field, and finally marks the new page valid in the chosen bank. While a refill is in progress, lookups are held off.

The default parameters give 8 offset bits, 6 bank-index bits and 3 alias bits, which is a 17-bit address. Setting the index width to 14 gives the full 25-bit arrangement: status indexed by address bits 24:8, banks by bits 21:8, and aliases in bits 24:22.

Top module: `vmap_two_bank`

## Requirements
- R1: After reset, every status entry is invalid, so every lookup misses. Every usage entry has both owner fields unowned (all ones) and its next field set to 10 (left bank next). `req_ready` is high.
- R2: A request accepted on a clock edge (`req_valid` and `req_ready` both high) gives `resp_valid` in the next cycle, with exactly one of `resp_hit`, `resp_miss` or `resp_fault` set. `resp_valid` is low in every other cycle. The status entry is selected by address bits [VA_W-1:OFF_W]. Status bit 0 is valid and bit 1 is the bank (1 = right). A clear valid bit gives a miss.
- R3: Map entry bit 31 is the access bit; when it is clear, every access faults. Bit 30 is the write bit; a write with bit 30 clear faults. A read needs only bit 31.
- R4: On a hit, `resp_paddr` is the entry's physical page number (bits 21:0), then address bits [OFF_W-1:0], then two zero bits. `resp_nocache` copies entry bit 22. On a miss, a fault or an idle cycle, both outputs are zero.
- R5: The bank index is address bits [OFF_W+IDX_W-1:OFF_W], and the status bank bit picks the left or right entry. Two pages that differ only in their alias bits can hit at the same time.
- R6: A refill that is not pinned, for a page that owns neither bank of its pair, uses the next field to choose the bank: 10 selects left, and 01 or 00 select right. Afterwards the field becomes the other bank (left becomes 01, right becomes 10). A value of 00 stays 00.
- R7: A pinned refill (`refill_wired` = 1) always installs in the left bank and sets the next field to 00. After that, unpinned refills to the pair always go to the right bank, and the pinned page keeps hitting.
- R8: When the chosen bank has an owner, the refill clears the status valid bits of both of that owner's map pages. Those pages are rebuilt from the owner's 3 stored alias bits and the pair index, with low index bit 0 and 1. Later lookups to either page miss.
- R9: If the refilled page already owns one bank of its pair, the refill uses that bank. It evicts nothing and leaves the next field unchanged.
- R10: A refill is accepted when the block is idle and `refill_valid` is high, and it takes priority over a request in the same cycle. `req_ready` stays low for the 4 cycles after acceptance. `req_ready` is also low while `refill_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_write | input | 1 | Request is a write |
| req_vaddr | input | VA_W (17) | Virtual word address |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| resp_valid | output | 1 | Response present |
| resp_hit | output | 1 | Translation succeeded |
| resp_miss | output | 1 | Status entry not valid |
| resp_fault | output | 1 | Permission check failed |
| resp_paddr | output | PA_W (32) | Physical byte address on a hit |
| resp_nocache | output | 1 | Cache-inhibit bit of the entry on a hit |
| refill_valid | input | 1 | Refill request |
| refill_page | input | PG_W (9) | Page number (alias and bank index) to install |
| refill_entry | input | 32 | Map entry to install |
| refill_wired | input | 1 | Pin the page in the left bank |

## Verification
The hardest state to reach is an eviction that follows a pinned install. The pair's next field has to be 00 and the right bank has to be owned already, so that a third aliasing page displaces the right owner and leaves the pinned left page alone. The stimulus gets there with a pinned refill and then two unpinned refills to the same pair, and it probes all three pages afterwards. The owner-match path is reached by refilling the sibling map page of a page that already owns its pair. A random phase mixes refills across eight aliases and a few pairs, and a behavioural table model predicts every cycle.

// File: rtl/vmap_pkg.sv
`timescale 1ns/1ps
package vmap_pkg;
  typedef enum logic [2:0] {
    RF_IDLE = 3'd0,
    RF_USE  = 3'd1,
    RF_INV  = 3'd2,
    RF_MAP  = 3'd3,
    RF_STAT = 3'd4
  } rf_state_e;

  localparam logic [1:0] NX_WIRED = 2'b00;
  localparam logic [1:0] NX_RIGHT = 2'b01;
  localparam logic [1:0] NX_LEFT  = 2'b10;

  localparam int ENT_W  = 32;
  localparam int ACC_B  = 31;
  localparam int WR_B   = 30;
  localparam int NC_B   = 22;
endpackage

// File: rtl/vmap_status_ram.sv
`timescale 1ns/1ps
module vmap_status_ram #(
  parameter int SIDX_W = 9,
  localparam int DEPTH = 1 << SIDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIDX_W-1:0] rd_idx,
  output logic              rd_valid,
  output logic              rd_bank,
  input  logic              clr_en,
  input  logic [SIDX_W-1:0] clr_idx0,
  input  logic [SIDX_W-1:0] clr_idx1,
  input  logic              wr_en,
  input  logic [SIDX_W-1:0] wr_idx,
  input  logic              wr_bank
);
  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] bsel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      if (clr_en) begin
        vld_q[clr_idx0] <= 1'b0;
        vld_q[clr_idx1] <= 1'b0;
      end
      if (wr_en) vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) bsel_q[wr_idx] <= wr_bank;
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_bank  = bsel_q[rd_idx];
endmodule

// File: rtl/vmap_bank_pair.sv
`timescale 1ns/1ps
module vmap_bank_pair #(
  parameter int IDX_W = 6,
  parameter int W     = 32,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic             rd_bank,
  output logic [W-1:0]     rd_data,
  input  logic             wr_en,
  input  logic             wr_bank,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_data
);
  logic [W-1:0] bank_rd [2];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == b[0])) mem[wr_idx] <= wr_data;
    end
    assign bank_rd[b] = mem[rd_idx];
  end

  assign rd_data = rd_bank ? bank_rd[1] : bank_rd[0];
endmodule

// File: rtl/vmap_refill_fsm.sv
`timescale 1ns/1ps
module vmap_refill_fsm
  import vmap_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int AL_W  = 3,
  localparam int PG_W   = IDX_W + AL_W,
  localparam int PR_W   = IDX_W - 1,
  localparam int PAIRS  = 1 << PR_W,
  localparam int OWN_W  = 2 * AL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PG_W-1:0]  start_page,
  input  logic [ENT_W-1:0] start_entry,
  input  logic             start_wired,
  output logic             busy,
  output logic             clr_en,
  output logic [PG_W-1:0]  clr_idx0,
  output logic [PG_W-1:0]  clr_idx1,
  output logic             st_wr_en,
  output logic [PG_W-1:0]  st_wr_idx,
  output logic             st_wr_bank,
  output logic             map_wr_en,
  output logic             map_wr_bank,
  output logic [IDX_W-1:0] map_wr_idx,
  output logic [ENT_W-1:0] map_wr_data
);
  rf_state_e state_q, state_d;
  logic [PG_W-1:0]  page_q;
  logic [ENT_W-1:0] ent_q;
  logic             wired_q, bank_q, evict_q, match_q;
  logic [OWN_W-1:0] owner_q;

  logic [1:0]       nx_tab  [PAIRS];
  logic [OWN_W-1:0] own_l   [PAIRS];
  logic [OWN_W-1:0] own_r   [PAIRS];

  logic [AL_W-1:0]  alias_q;
  logic [IDX_W-1:0] idx_q;
  logic [PR_W-1:0]  pr_q;
  logic [OWN_W-1:0] mine, cur_l, cur_r, victim;
  logic [1:0]       cur_nx, nx_new;
  logic             bank_d, match_d, evict_d;

  assign alias_q = page_q[PG_W-1 -: AL_W];
  assign idx_q   = page_q[IDX_W-1:0];
  assign pr_q    = idx_q[IDX_W-1:1];
  assign mine    = {{(OWN_W-AL_W){1'b0}}, alias_q};
  assign cur_l   = own_l[pr_q];
  assign cur_r   = own_r[pr_q];
  assign cur_nx  = nx_tab[pr_q];

  // Bank choice: pin request, then owner match, then alternation field.
  always_comb begin
    match_d = 1'b0;
    if (wired_q) begin
      bank_d = 1'b0;
    end else if (cur_l == mine) begin
      bank_d = 1'b0; match_d = 1'b1;
    end else if (cur_r == mine) begin
      bank_d = 1'b1; match_d = 1'b1;
    end else begin
      bank_d = (cur_nx == NX_WIRED) || (cur_nx == NX_RIGHT);
    end
    victim  = bank_d ? cur_r : cur_l;
    evict_d = !match_d && (victim != '1);
  end

  always_comb begin
    if (wired_q)                nx_new = NX_WIRED;
    else if (match_q)           nx_new = cur_nx;
    else if (cur_nx == NX_WIRED) nx_new = NX_WIRED;
    else                        nx_new = bank_q ? NX_LEFT : NX_RIGHT;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RF_IDLE: if (start) state_d = RF_USE;
      RF_USE:  state_d = RF_INV;
      RF_INV:  state_d = RF_MAP;
      RF_MAP:  state_d = RF_STAT;
      RF_STAT: state_d = RF_IDLE;
      default: state_d = RF_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RF_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (state_q == RF_IDLE && start) begin
      page_q  <= start_page;
      ent_q   <= start_entry;
      wired_q <= start_wired;
    end
    if (state_q == RF_USE) begin
      bank_q  <= bank_d;
      match_q <= match_d;
      evict_q <= evict_d;
      owner_q <= victim;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < PAIRS; p++) begin
        nx_tab[p] <= NX_LEFT;
        own_l[p]  <= '1;
        own_r[p]  <= '1;
      end
    end else if (state_q == RF_MAP) begin
      nx_tab[pr_q] <= nx_new;
      if (bank_q) own_r[pr_q] <= mine;
      else        own_l[pr_q] <= mine;
    end
  end

  assign busy        = (state_q != RF_IDLE);
  assign clr_en      = (state_q == RF_INV) && evict_q;
  assign clr_idx0    = {owner_q[AL_W-1:0], pr_q, 1'b0};
  assign clr_idx1    = {owner_q[AL_W-1:0], pr_q, 1'b1};
  assign map_wr_en   = (state_q == RF_MAP);
  assign map_wr_bank = bank_q;
  assign map_wr_idx  = idx_q;
  assign map_wr_data = ent_q;
  assign st_wr_en    = (state_q == RF_STAT);
  assign st_wr_idx   = page_q;
  assign st_wr_bank  = bank_q;

  logic own_unused;
  assign own_unused = ^owner_q[OWN_W-1:AL_W];
endmodule

// File: rtl/vmap_two_bank.sv
`timescale 1ns/1ps
module vmap_two_bank
  import vmap_pkg::*;
#(
  parameter int OFF_W = 8,
  parameter int IDX_W = 6,
  parameter int AL_W  = 3,
  parameter int PPN_W = 22,
  localparam int PG_W = IDX_W + AL_W,
  localparam int VA_W = OFF_W + PG_W,
  localparam int PA_W = PPN_W + OFF_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  output logic             resp_valid,
  output logic             resp_hit,
  output logic             resp_miss,
  output logic             resp_fault,
  output logic [PA_W-1:0]  resp_paddr,
  output logic             resp_nocache,
  input  logic             refill_valid,
  input  logic [PG_W-1:0]  refill_page,
  input  logic [ENT_W-1:0] refill_entry,
  input  logic             refill_wired
);
  logic             refill_busy, clr_en, st_wr_en, st_wr_bank;
  logic [PG_W-1:0]  clr_idx0, clr_idx1, st_wr_idx;
  logic             map_wr_en, map_wr_bank;
  logic [IDX_W-1:0] map_wr_idx;
  logic [ENT_W-1:0] map_wr_data, lk_entry;
  logic             st_valid, st_bank, accept;

  vmap_status_ram #(.SIDX_W(PG_W)) u_status (
    .clk(clk), .rst_n(rst_n),
    .rd_idx(req_vaddr[VA_W-1:OFF_W]), .rd_valid(st_valid), .rd_bank(st_bank),
    .clr_en(clr_en), .clr_idx0(clr_idx0), .clr_idx1(clr_idx1),
    .wr_en(st_wr_en), .wr_idx(st_wr_idx), .wr_bank(st_wr_bank)
  );

  vmap_bank_pair #(.IDX_W(IDX_W), .W(ENT_W)) u_banks (
    .clk(clk), .rd_idx(req_vaddr[OFF_W +: IDX_W]), .rd_bank(st_bank), .rd_data(lk_entry),
    .wr_en(map_wr_en), .wr_bank(map_wr_bank), .wr_idx(map_wr_idx), .wr_data(map_wr_data)
  );

  vmap_refill_fsm #(.IDX_W(IDX_W), .AL_W(AL_W)) u_refill (
    .clk(clk), .rst_n(rst_n),
    .start(refill_valid && !refill_busy), .start_page(refill_page),
    .start_entry(refill_entry), .start_wired(refill_wired),
    .busy(refill_busy), .clr_en(clr_en), .clr_idx0(clr_idx0), .clr_idx1(clr_idx1),
    .st_wr_en(st_wr_en), .st_wr_idx(st_wr_idx), .st_wr_bank(st_wr_bank),
    .map_wr_en(map_wr_en), .map_wr_bank(map_wr_bank), .map_wr_idx(map_wr_idx),
    .map_wr_data(map_wr_data)
  );

  assign req_ready = !refill_busy && !refill_valid;
  assign accept    = req_valid && req_ready;

  logic            rv_d, hit_d, miss_d, flt_d, nc_d;
  logic [PA_W-1:0] pa_d;

  always_comb begin
    rv_d = accept; hit_d = 1'b0; miss_d = 1'b0; flt_d = 1'b0;
    nc_d = 1'b0;   pa_d = '0;
    if (accept) begin
      if (!st_valid) begin
        miss_d = 1'b1;
      end else if (!lk_entry[ACC_B] || (req_write && !lk_entry[WR_B])) begin
        flt_d = 1'b1;
      end else begin
        hit_d = 1'b1;
        pa_d  = {lk_entry[PPN_W-1:0], req_vaddr[OFF_W-1:0], 2'b00};
        nc_d  = lk_entry[NC_B];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0; resp_hit <= 1'b0; resp_miss <= 1'b0;
      resp_fault <= 1'b0; resp_paddr <= '0; resp_nocache <= 1'b0;
    end else begin
      resp_valid <= rv_d; resp_hit <= hit_d; resp_miss <= miss_d;
      resp_fault <= flt_d; resp_paddr <= pa_d; resp_nocache <= nc_d;
    end
  end

  logic lk_unused;
  assign lk_unused = ^lk_entry[29:23];
endmodule

// File: rtl/vmap_two_bank_chk.sv
`timescale 1ns/1ps
module vmap_two_bank_chk #(
  parameter int OFF_W = 8,
  parameter int PA_W  = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [OFF_W-1:0] req_off,
  input logic             resp_valid,
  input logic             resp_hit,
  input logic             resp_miss,
  input logic             resp_fault,
  input logic [PA_W-1:0]  resp_paddr,
  input logic             resp_nocache,
  input logic             refill_valid,
  input logic             refill_busy
);
  assert_resp_follows_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid);
  assert_no_stray_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !resp_valid);
  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ($countones({resp_hit, resp_miss, resp_fault}) == 1));
  assert_offset_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    resp_hit |-> (resp_paddr[OFF_W+1:0] == {$past(req_off), 2'b00}));
  assert_quiet_nonhit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_hit |-> (resp_paddr == '0 && !resp_nocache));
  assert_busy_stalls_R10: assert property (@(posedge clk) disable iff (!rst_n)
    refill_busy |-> !req_ready);
  assert_refill_starts_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (refill_valid && !refill_busy) |=> refill_busy);
  assert_idle_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!refill_busy && !refill_valid) |-> req_ready);
endmodule

bind vmap_two_bank vmap_two_bank_chk #(.OFF_W(OFF_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_off(req_vaddr[OFF_W-1:0]), .resp_valid(resp_valid), .resp_hit(resp_hit),
  .resp_miss(resp_miss), .resp_fault(resp_fault), .resp_paddr(resp_paddr),
  .resp_nocache(resp_nocache), .refill_valid(refill_valid), .refill_busy(refill_busy)
);

// File: tb/vmap_two_bank_test.sv
`timescale 1ns/1ps
module vmap_two_bank_test;
  localparam int OFF_W = 8, IDX_W = 6, AL_W = 3, PG_W = 9, VA_W = 17, PA_W = 32;
  localparam int NPG = 1 << PG_W, NIX = 1 << IDX_W, NPR = NIX / 2, UNOWN = 63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [VA_W-1:0] req_vaddr = '0;
  logic refill_valid = 1'b0, refill_wired = 1'b0;
  logic [PG_W-1:0] refill_page = '0;
  logic [31:0] refill_entry = '0;
  logic req_ready, resp_valid, resp_hit, resp_miss, resp_fault, resp_nocache;
  logic [PA_W-1:0] resp_paddr;

  always #2 clk = ~clk;

  vmap_two_bank uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_vaddr(req_vaddr), .req_ready(req_ready), .resp_valid(resp_valid),
    .resp_hit(resp_hit), .resp_miss(resp_miss), .resp_fault(resp_fault),
    .resp_paddr(resp_paddr), .resp_nocache(resp_nocache), .refill_valid(refill_valid),
    .refill_page(refill_page), .refill_entry(refill_entry), .refill_wired(refill_wired)
  );

  int checks = 0, fails = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // Behavioural model of the tables
  bit m_v [NPG];
  bit m_b [NPG];
  logic [31:0] m_bank [2][NIX];
  int m_nx [NPR];
  int m_ol [NPR];
  int m_or [NPR];
  int busy_cnt;
  bit e_rv, e_hit, e_miss, e_flt, e_nc;
  logic [PA_W-1:0] e_pa;

  task automatic model_reset();
    for (int i = 0; i < NPG; i++) m_v[i] = 0;
    for (int p = 0; p < NPR; p++) begin m_nx[p] = 2; m_ol[p] = UNOWN; m_or[p] = UNOWN; end
    busy_cnt = 0;
    {e_rv, e_hit, e_miss, e_flt, e_nc} = '0; e_pa = '0;
  endtask

  task automatic model_refill(input int page, input logic [31:0] ent, input bit w);
    int al, ix, pr, bank, victim;
    bit match;
    al = page >> IDX_W; ix = page % NIX; pr = ix / 2; match = 0;
    if (w) bank = 0;
    else if (m_ol[pr] == al) begin bank = 0; match = 1; end
    else if (m_or[pr] == al) begin bank = 1; match = 1; end
    else bank = (m_nx[pr] == 2 || m_nx[pr] == 3) ? 0 : 1;
    victim = bank ? m_or[pr] : m_ol[pr];
    if (!match && victim != UNOWN) begin
      m_v[(victim % 8) * NIX + pr * 2] = 0;
      m_v[(victim % 8) * NIX + pr * 2 + 1] = 0;
    end
    m_bank[bank][ix] = ent;
    if (bank == 1) m_or[pr] = al; else m_ol[pr] = al;
    if (w) m_nx[pr] = 0;
    else if (!match && m_nx[pr] != 0) m_nx[pr] = bank ? 2 : 1;
    m_v[page] = 1; m_b[page] = bank[0];
  endtask

  always @(negedge clk) begin
    if (!rst_n) model_reset();
    else begin
      bit rdy;
      rdy = (busy_cnt == 0) && !refill_valid;
      chk(req_ready == rdy, "R10", "req_ready", req_ready, rdy);
      chk(resp_valid == e_rv, "R2", "resp_valid", resp_valid, e_rv);
      chk({resp_hit, resp_miss, resp_fault} == {e_hit, e_miss, e_flt}, cur_req,
          "outcome hit/miss/fault", {resp_hit, resp_miss, resp_fault}, {e_hit, e_miss, e_flt});
      chk(resp_paddr == e_pa && resp_nocache == e_nc, "R4", "paddr/nocache",
          {resp_nocache, resp_paddr}, {e_nc, e_pa});
      {e_rv, e_hit, e_miss, e_flt, e_nc} = '0; e_pa = '0;
      if (req_valid && rdy) begin
        int pg, ix;
        logic [31:0] en;
        e_rv = 1;
        pg = int'(req_vaddr >> OFF_W); ix = pg % NIX;
        if (!m_v[pg]) e_miss = 1;
        else begin
          en = m_bank[m_b[pg]][ix];
          if (!en[31] || (req_write && !en[30])) e_flt = 1;
          else begin
            e_hit = 1; e_pa = {en[21:0], req_vaddr[7:0], 2'b00}; e_nc = en[22];
          end
        end
      end
      if (busy_cnt > 0) busy_cnt--;
      else if (refill_valid) begin
        model_refill(int'(refill_page), refill_entry, refill_wired);
        busy_cnt = 4;
      end
    end
  end

  function automatic logic [VA_W-1:0] va(input int a, input int i, input int o);
    return {a[2:0], i[5:0], o[7:0]};
  endfunction

  // kind: 0 miss, 1 hit, 2 fault
  int last_kind;
  logic [PA_W-1:0] last_pa;
  logic last_nc;

  task automatic lookup(input logic [VA_W-1:0] a, input bit wr);
    bit acc;
    @(posedge clk); #1;
    req_valid = 1; req_write = wr; req_vaddr = a;
    do begin @(posedge clk); acc = req_ready; end while (!acc);
    #1 req_valid = 0;
    @(negedge clk);
    last_kind = resp_hit ? 1 : (resp_fault ? 2 : 0);
    last_pa = resp_paddr; last_nc = resp_nocache;
  endtask

  task automatic refill(input int a, input int i, input logic [31:0] ent, input bit w);
    @(posedge clk); #1;
    refill_valid = 1; refill_page = {a[2:0], i[5:0]}; refill_entry = ent; refill_wired = w;
    @(posedge clk); #1;
    refill_valid = 0; refill_wired = 0;
    repeat (5) @(posedge clk);
  endtask

  task automatic expect_kind(input logic [VA_W-1:0] a, input bit wr, input int k,
                             input string tag);
    lookup(a, wr);
    chk(last_kind == k, tag, "direct outcome", last_kind, k);
  endtask

  localparam logic [31:0] RW = 32'hC000_0000;
  localparam logic [31:0] RO = 32'h8000_0000;

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1: cold state misses everywhere
    cur_req = "R1";
    expect_kind(va(0, 0, 0), 0, 0, "R1");
    expect_kind(va(7, 63, 255), 1, 0, "R1");
    // R5/R4: first install goes left, translation correct
    cur_req = "R5";
    refill(1, 4, RW | 32'h0001_2345, 0);
    expect_kind(va(1, 4, 8'hA5), 0, 1, "R5");
    chk(last_pa == {22'h01_2345, 8'hA5, 2'b00}, "R4", "paddr", last_pa, {22'h01_2345, 8'hA5, 2'b00});
    expect_kind(va(1, 4, 3), 1, 1, "R3");
    expect_kind(va(1, 5, 3), 0, 0, "R5");
    // R6: alternation puts second alias in right bank, both hit
    cur_req = "R6";
    refill(2, 4, RW | 32'h0040_0777, 0);
    expect_kind(va(2, 4, 1), 0, 1, "R6");
    chk(last_nc == 1, "R4", "nocache", last_nc, 1);
    expect_kind(va(1, 4, 1), 0, 1, "R5");
    // R8: third alias goes left, evicting alias 1's pair
    cur_req = "R8";
    refill(1, 5, RW | 32'h0000_0011, 0);
    refill(3, 4, RW | 32'h0000_0033, 0);
    expect_kind(va(1, 4, 0), 0, 0, "R8");
    expect_kind(va(1, 5, 0), 0, 0, "R8");
    expect_kind(va(2, 4, 0), 0, 1, "R8");
    // R9: sibling of current left owner reuses left, right untouched
    cur_req = "R9";
    refill(3, 5, RW | 32'h0000_0035, 0);
    expect_kind(va(3, 5, 0), 0, 1, "R9");
    expect_kind(va(2, 4, 0), 0, 1, "R9");
    refill(5, 4, RW | 32'h0000_0055, 0);
    expect_kind(va(2, 4, 0), 0, 0, "R6");
    expect_kind(va(3, 4, 0), 0, 1, "R9");
    // R3: permission bits
    cur_req = "R3";
    refill(0, 20, 32'h0000_0001, 0);
    expect_kind(va(0, 20, 0), 0, 2, "R3");
    refill(0, 22, RO | 32'h0000_0002, 0);
    expect_kind(va(0, 22, 0), 0, 1, "R3");
    expect_kind(va(0, 22, 0), 1, 2, "R3");
    // R7: pinned page keeps the left bank
    cur_req = "R7";
    refill(0, 8, RW | 32'h0000_0100, 1);
    refill(1, 8, RW | 32'h0000_0101, 0);
    refill(2, 8, RW | 32'h0000_0102, 0);
    expect_kind(va(0, 8, 0), 0, 1, "R7");
    expect_kind(va(1, 8, 0), 0, 0, "R7");
    expect_kind(va(2, 8, 0), 0, 1, "R7");
    refill(4, 9, RW | 32'h0000_0104, 0);
    expect_kind(va(0, 8, 0), 1, 1, "R7");
    expect_kind(va(2, 8, 0), 0, 0, "R7");
    // R10: request held off while refill is raised
    cur_req = "R10";
    @(posedge clk); #1;
    req_valid = 1; req_vaddr = va(0, 8, 4); req_write = 0;
    refill_valid = 1; refill_page = {3'd6, 6'd30}; refill_entry = RW; refill_wired = 0;
    @(posedge clk); #1 refill_valid = 0;
    repeat (6) @(posedge clk);
    #1 req_valid = 0;
    // Random mix, model compared every cycle
    cur_req = "R5";
    for (int n = 0; n < 400; n++) begin
      int a, i;
      a = $urandom_range(0, 7); i = $urandom_range(0, 3);
      if ($urandom_range(0, 3) == 0)
        refill(a, i, {$urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 7'd0,
                      1'b0, $urandom_range(0, 1) == 1, 22'($urandom)}, $urandom_range(0, 15) == 0);
      else lookup(va(a, i, $urandom_range(0, 255)), $urandom_range(0, 1) == 1);
    end
    repeat (3) @(posedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule